// File: doc/BRIEF.md
# Configurable Output Macrocell

One output cell of a registered programmable logic device. It receives a sum-of-products value from the logic array, a dedicated output-enable term, the shared asynchronous-clear and synchronous-set terms, and a clock. It drives one pin and returns a feedback signal to the array.

Two configuration bits set the cell up. One picks registered or combinational operation. The other picks true or inverted pin polarity. In registered mode the pin shows a D flip-flop that captures the sum term on each rising clock edge. The array then sees the complemented register output, so the pin cannot serve as an input. In combinational mode the sum term reaches the pin directly, and the array sees whatever level is on the pin. The pin can be an output, an input, or a term-controlled bidirectional line. The bidirectional pin is modelled as three separate signals: pin-in, pin-out and pin output-enable.

Top module: `out_cell`

## Requirements
- R1: `pin_o` equals `(mode_reg_i ? q : sum_i) ^ pol_inv_i`, where q is the internal flip-flop state. `mode_reg_i`=1 selects registered mode and `pol_inv_i`=1 selects inverted polarity.
- R2: While `aclr_term_i` is 1, q is 0 at once, with no clock edge needed. In registered mode the pin therefore reads `pol_inv_i`, so it is high under inverted polarity.
- R3: On a rising edge of `clk_i` with neither clear nor set active, q takes `sum_i`. The flip-flop keeps capturing in both modes.
- R4: On a rising edge of `clk_i` with `spre_term_i`=1 and `aclr_term_i`=0, q becomes 1.
- R5: When `aclr_term_i` and `spre_term_i` are both 1, q stays 0 across clock edges.
- R6: While `rst_ni` is 0, q is 0.
- R7: In registered mode `fb_o` equals the complement of q, and `pin_i` has no effect on it.
- R8: In combinational mode `fb_o` equals `pin_i`.
- R9: `fb_n_o` is always the complement of `fb_o`.
- R10: `pin_oe_o` follows `oe_sel_i` as follows: 2'b01 forces it to 1, 2'b10 forces it to 0, and 2'b00 or 2'b11 make it equal `oe_term_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low power-up clear of the register |
| sum_i | input | 1 | Sum-of-products term from the array |
| oe_term_i | input | 1 | Dedicated output-enable product term |
| aclr_term_i | input | 1 | Shared asynchronous clear term |
| spre_term_i | input | 1 | Shared synchronous set term |
| mode_reg_i | input | 1 | 1 = registered, 0 = combinational |
| pol_inv_i | input | 1 | 1 = inverted pin polarity |
| oe_sel_i | input | 2 | Output-enable source select |
| pin_i | input | 1 | Level seen on the pin |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback to the array, true form |
| fb_n_o | output | 1 | Feedback to the array, complement form |

## Verification
The cell has no parameters, so the bench builds the one default configuration. That configuration covers all four mode and polarity settings and all four output-enable selections. The random stimulus changes configuration, pin level and both shared terms on every cycle. This exposes mode switches while the register holds state, and clear or set pulses under either polarity. Directed cases cover clear and set asserted together, a clear that rises in mid-cycle, and external pin levels that must reach feedback only in combinational mode.

// File: rtl/out_cell_pkg.sv
package out_cell_pkg;
  typedef enum logic [1:0] {
    OE_TERM     = 2'b00,
    OE_ON       = 2'b01,
    OE_OFF      = 2'b10,
    OE_TERM_ALT = 2'b11
  } oe_sel_e;
endpackage

// File: rtl/out_cell_ff.sv
module out_cell_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic aclr_i,
  input  logic spre_i,
  input  logic d_i,
  output logic q_o
);
  logic clr_n;
  assign clr_n = rst_ni & ~aclr_i;

  // clear dominates set: set is only seen on a clock edge
  always_ff @(posedge clk_i or negedge clr_n) begin
    if (!clr_n)      q_o <= 1'b0;
    else if (spre_i) q_o <= 1'b1;
    else             q_o <= d_i;
  end
endmodule

// File: rtl/out_cell_pin_mux.sv
module out_cell_pin_mux (
  input  logic       mode_reg_i,
  input  logic       pol_inv_i,
  input  logic       q_i,
  input  logic       sum_i,
  input  logic [1:0] oe_sel_i,
  input  logic       oe_term_i,
  output logic       pin_o,
  output logic       pin_oe_o
);
  import out_cell_pkg::*;

  always_comb begin
    unique case ({mode_reg_i, pol_inv_i})
      2'b00:   pin_o = sum_i;
      2'b01:   pin_o = ~sum_i;
      2'b10:   pin_o = q_i;
      default: pin_o = ~q_i;
    endcase
  end

  always_comb begin
    unique case (oe_sel_e'(oe_sel_i))
      OE_ON:   pin_oe_o = 1'b1;
      OE_OFF:  pin_oe_o = 1'b0;
      default: pin_oe_o = oe_term_i;
    endcase
  end
endmodule

// File: rtl/out_cell_fb_mux.sv
module out_cell_fb_mux (
  input  logic mode_reg_i,
  input  logic q_i,
  input  logic pin_i,
  output logic fb_o,
  output logic fb_n_o
);
  logic fb;
  assign fb     = mode_reg_i ? ~q_i : pin_i;
  assign fb_o   = fb;
  assign fb_n_o = ~fb;
endmodule

// File: rtl/out_cell.sv
module out_cell (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sum_i,
  input  logic       oe_term_i,
  input  logic       aclr_term_i,
  input  logic       spre_term_i,
  input  logic       mode_reg_i,
  input  logic       pol_inv_i,
  input  logic [1:0] oe_sel_i,
  input  logic       pin_i,
  output logic       pin_o,
  output logic       pin_oe_o,
  output logic       fb_o,
  output logic       fb_n_o
);
  logic q_r;

  out_cell_ff u_ff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .aclr_i (aclr_term_i),
    .spre_i (spre_term_i),
    .d_i    (sum_i),
    .q_o    (q_r)
  );

  out_cell_pin_mux u_pin (
    .mode_reg_i (mode_reg_i),
    .pol_inv_i  (pol_inv_i),
    .q_i        (q_r),
    .sum_i      (sum_i),
    .oe_sel_i   (oe_sel_i),
    .oe_term_i  (oe_term_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o)
  );

  out_cell_fb_mux u_fb (
    .mode_reg_i (mode_reg_i),
    .q_i        (q_r),
    .pin_i      (pin_i),
    .fb_o       (fb_o),
    .fb_n_o     (fb_n_o)
  );
endmodule

// File: rtl/out_cell_chk.sv
module out_cell_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sum_i,
  input logic       aclr_term_i,
  input logic       spre_term_i,
  input logic       mode_reg_i,
  input logic       pol_inv_i,
  input logic [1:0] oe_sel_i,
  input logic       pin_i,
  input logic       pin_o,
  input logic       pin_oe_o,
  input logic       fb_o,
  input logic       fb_n_o,
  input logic       reg_q_i
);
  a_r2_clear_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aclr_term_i && mode_reg_i) |-> (pin_o == pol_inv_i));

  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aclr_term_i && !spre_term_i) |=> (reg_q_i == $past(sum_i)) || aclr_term_i);

  a_r4_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spre_term_i && !aclr_term_i) |=> (reg_q_i || aclr_term_i));

  a_r5_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aclr_term_i && spre_term_i) |-> !reg_q_i);

  a_r7_fb_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_reg_i |-> (fb_o != reg_q_i));

  a_r8_fb_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_reg_i |-> (fb_o == pin_i));

  a_r9_fb_compl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_n_o != fb_o);

  a_r10_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_sel_i == 2'b10) |-> !pin_oe_o);
endmodule

bind out_cell out_cell_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sum_i       (sum_i),
  .aclr_term_i (aclr_term_i),
  .spre_term_i (spre_term_i),
  .mode_reg_i  (mode_reg_i),
  .pol_inv_i   (pol_inv_i),
  .oe_sel_i    (oe_sel_i),
  .pin_i       (pin_i),
  .pin_o       (pin_o),
  .pin_oe_o    (pin_oe_o),
  .fb_o        (fb_o),
  .fb_n_o      (fb_n_o),
  .reg_q_i     (q_r)
);

// File: tb/tb_out_cell.sv
`timescale 1ns/1ps
module tb_out_cell;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sum_i = 1'b0, oe_term_i = 1'b0, aclr_term_i = 1'b0, spre_term_i = 1'b0;
  logic       mode_reg_i = 1'b1, pol_inv_i = 1'b0, pin_i = 1'b0;
  logic [1:0] oe_sel_i = 2'b00;
  logic       pin_o, pin_oe_o, fb_o, fb_n_o;

  int total = 0;
  int fails = 0;
  logic mq = 1'b0;

  always #2 clk_i = ~clk_i;

  out_cell dut (.*);

  function automatic logic exp_pin(logic m, logic inv, logic q, logic s);
    return (m ? q : s) ^ inv;
  endfunction
  function automatic logic exp_oe(logic [1:0] sel, logic t);
    return (sel == 2'b01) ? 1'b1 : (sel == 2'b10) ? 1'b0 : t;
  endfunction
  function automatic logic exp_fb(logic m, logic q, logic p);
    return m ? ~q : p;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_all();
    #0.5;
    chk("R1 pin value", pin_o, exp_pin(mode_reg_i, pol_inv_i, mq, sum_i));
    chk("R10 output enable", pin_oe_o, exp_oe(oe_sel_i, oe_term_i));
    if (mode_reg_i) chk("R7 registered feedback", fb_o, exp_fb(1'b1, mq, pin_i));
    else            chk("R8 pin feedback", fb_o, pin_i);
    chk("R9 feedback complement", fb_n_o, ~fb_o);
  endtask

  // advance one clock edge and update the model from the inputs seen there
  task automatic step();
    @(posedge clk_i);
    if (!rst_ni || aclr_term_i) mq = 1'b0;
    else if (spre_term_i)       mq = 1'b1;
    else                        mq = sum_i;
    @(negedge clk_i);
  endtask

  task automatic drive(logic m, logic inv, logic s, logic ac, logic sp,
                       logic [1:0] sel, logic t, logic p);
    mode_reg_i = m; pol_inv_i = inv; sum_i = s; aclr_term_i = ac;
    spre_term_i = sp; oe_sel_i = sel; oe_term_i = t; pin_i = p;
    if (ac || !rst_ni) mq = 1'b0;
  endtask

  initial begin
    #200000;
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c11));
    @(negedge clk_i);
    // R6: held in reset, register reads 0
    drive(1, 0, 1, 0, 0, 2'b01, 0, 0);
    step();
    #0.5 chk("R6 reset pin true", pin_o, 1'b0);
    drive(1, 1, 1, 0, 0, 2'b01, 0, 1);
    #0.5 chk("R6 reset pin inverted", pin_o, 1'b1);
    chk("R7 reset feedback", fb_o, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R3 capture
    drive(1, 0, 1, 0, 0, 2'b01, 0, 0);
    step();
    #0.5 chk("R3 capture one", pin_o, 1'b1);
    // R4 set overrides sum=0
    drive(1, 0, 0, 0, 1, 2'b01, 0, 0);
    step();
    #0.5 chk("R4 set", pin_o, 1'b1);
    // R2 mid-cycle clear, no edge
    @(negedge clk_i);
    #1 aclr_term_i = 1'b1;
    #0.3 chk("R2 immediate clear", pin_o, 1'b0);
    // R5 clear with set across an edge
    @(negedge clk_i);
    drive(1, 0, 1, 1, 1, 2'b01, 0, 0);
    step();
    #0.5 chk("R5 clear beats set", pin_o, 1'b0);
    // R2 clear shows high under inverted polarity
    drive(1, 1, 1, 1, 0, 2'b01, 0, 0);
    #0.5 chk("R2 clear inverted pin", pin_o, 1'b1);
    // R2 release: stays 0 until an edge
    @(negedge clk_i);
    drive(1, 0, 1, 0, 0, 2'b01, 0, 0);
    #0.5 chk("R2 held until edge", pin_o, 1'b0);
    // R7 pin level ignored in registered mode
    @(negedge clk_i);
    drive(1, 0, 0, 1, 0, 2'b10, 0, 1);
    #0.5 chk("R7 pin ignored hi", fb_o, 1'b1);
    pin_i = 1'b0;
    #0.5 chk("R7 pin ignored lo", fb_o, 1'b1);
    // R8 combinational pin feedback, forced-off output
    @(negedge clk_i);
    drive(0, 0, 1, 0, 0, 2'b10, 1, 0);
    #0.5 chk("R8 pin low fed back", fb_o, 1'b0);
    chk("R10 forced off", pin_oe_o, 1'b0);
    chk("R1 comb true", pin_o, 1'b1);
    pin_i = 1'b1;
    #0.5 chk("R8 pin high fed back", fb_o, 1'b1);
    step();

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0], r[1], r[2], r[7:4] == 4'h0, r[10:8] == 3'h0,
            r[12:11], r[13], r[14]);
      check_all();
      step();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule